// File: doc/BRIEF.md
# Edge-Counting Timer Channel

This block is one timer channel that counts transitions on an external event input. An 8-bit mode register sets it up. The register chooses which transition is counted, where the count direction comes from, and what happens when the counter passes its top or bottom value. Software reaches the channel through a small register port with three locations:

| Address | Write | Read |
|---|---|---|
| 0 | mode register | mode register |
| 1 | reload value | live counter value |
| 2 | software direction flag (bit 0) | software direction flag |

Each time the counter passes its top or bottom value it raises a one-cycle interrupt request. When the pulse output is enabled, the pulse line also changes level at that moment.

Mode register fields:

| Bits | Field |
|---|---|
| [1:0] | operating mode |
| 2 | pulse enable |
| 3 | edge choice |
| 4 | direction source |
| 5 | reserved, write 0 |
| 6 | free-run |
| 7 | unused |

The event pin and the direction pin are both asynchronous. They pass through a two-flop synchronizer before any logic uses them. The counter itself is 16 bits wide by default. When the channel is not in event-count mode it holds its value. Only in that stopped state does writing the reload location also preset the counter.

Top module: `evt_counter_timer`

## Requirements
- R1: After reset the mode register reads 0x00, the counter reads 0, the direction flag reads 0, and irq_o, pulse_o and pulse_oe_o are 0.
- R2: The counter moves only while mode bits [1:0] equal 2'b01. With any other value it holds, even when event edges arrive.
- R3: Mode bit 3 picks the counted transition: 1 counts rising edges of evt_i and 0 counts falling edges. The other transition is not counted.
- R4: With mode bit 4 equal to 0, the direction comes from the flag at address 2, bit 0: 1 counts up and 0 counts down. The level of dir_i is then ignored.
- R5: With mode bit 4 equal to 1, the direction comes from dir_i: high counts up and low counts down. The software flag is then ignored.
- R6: With mode bit 6 equal to 0 (reload), a counted edge at 0xFFFF going up, or at 0 going down, loads the counter from the reload register.
- R7: With mode bit 6 equal to 1 (free-run), the counter wraps from 0xFFFF to 0 going up and from 0 to 0xFFFF going down.
- R8: Every overflow or underflow gives an irq_o pulse exactly one clock long, in the same clock in which the counter takes its new value.
- R9: pulse_oe_o follows mode bit 2. While bit 2 is 1, pulse_o changes level on every overflow or underflow. While bit 2 is 0, pulse_o stays 0.
- R10: Writing address 1 while the counter is stopped loads the counter as well as the reload register. While it runs, the write changes only the reload register.
- R11: An input edge changes the counter on the third rising clock edge after the input changes. Each edge moves the counter by exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 mode, 1 reload, 2 direction flag |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address (combinational read) |
| rd_data_o | output | 16 | Read data; address 1 returns the live counter |
| evt_i | input | 1 | External event input (asynchronous) |
| dir_i | input | 1 | External direction input (asynchronous) |
| pulse_o | output | 1 | Pulse output, changes level on overflow or underflow |
| pulse_oe_o | output | 1 | Pulse output enable |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The boundary transitions are the hardest cases to reach from the ports. Walking the counter to 0xFFFF or 0 one edge at a time would take tens of thousands of edges. Instead, the bench stops the channel and uses the preset-on-write path to place the counter one or two steps away from the boundary. It then restarts the channel and runs a few edges through each combination of direction and reload/free-run. For each combination it tracks the interrupt count and the pulse level in an arithmetic model. A separate sweep covers every combination of edge choice, direction source and direction value, with the unused direction input driven to the opposite value.

// File: rtl/evt_pkg.sv
package evt_pkg;

  localparam int ADDR_W = 2;
  localparam int MODE_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DIR  = 2'd2;

  localparam logic [1:0] OP_EVENT = 2'b01;

  typedef struct packed {
    logic       spare7;
    logic       free_run;
    logic       rsvd5;
    logic       dir_pin;
    logic       edge_rise;
    logic       pulse_en;
    logic [1:0] op_mode;
  } evt_mode_t;

endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 2'b00;
    else         rst_q <= {rst_q[0], 1'b1};
  end

  assign rst_no = rst_q[1];
endmodule

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             evt_i,
  input  logic             rise_sel_i,
  input  logic             up_i,
  input  logic             free_run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic             prev_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit;
  logic             cnt_en;

  // Edge detection on the synchronized level
  assign hit    = run_i && (rise_sel_i ? (evt_i && !prev_q) : (!evt_i && prev_q));
  assign wrap_o = hit && (up_i ? (cnt_q == '1) : (cnt_q == '0));
  assign cnt_en = hit || load_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (wrap_o) begin
      if (free_run_i) cnt_d = up_i ? '0 : '1;
      else            cnt_d = reload_i;
    end else if (hit) begin
      cnt_d = up_i ? cnt_q + 1'b1 : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= evt_i;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_counter_timer.sv
module evt_counter_timer
  import evt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  input  logic              evt_i,
  input  logic              dir_i,
  output logic              pulse_o,
  output logic              pulse_oe_o,
  output logic              irq_o
);
  localparam int PAD_MODE = CNT_W - MODE_W;
  localparam int PAD_FLAG = CNT_W - 1;

  logic             rst_n;
  evt_mode_t        mode_q, mode_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             flag_q, flag_d;
  logic             pulse_q, pulse_d;
  logic             irq_q;
  logic             mode_we, reload_we, flag_we;
  logic [1:0]       pins_sync;
  logic             running, count_up, load_cnt, wrap;
  logic [CNT_W-1:0] cnt_q;

  evt_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n));

  evt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_n),
    .async_i({dir_i, evt_i}), .sync_o(pins_sync)
  );

  assign running  = (mode_q.op_mode == OP_EVENT);
  assign count_up = mode_q.dir_pin ? pins_sync[1] : flag_q;
  assign mode_we   = wr_en_i && (wr_addr_i == ADDR_MODE);
  assign reload_we = wr_en_i && (wr_addr_i == ADDR_CNT);
  assign flag_we   = wr_en_i && (wr_addr_i == ADDR_DIR);
  assign load_cnt  = reload_we && !running;

  evt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_n),
    .run_i(running), .evt_i(pins_sync[0]),
    .rise_sel_i(mode_q.edge_rise), .up_i(count_up),
    .free_run_i(mode_q.free_run),
    .load_i(load_cnt), .load_val_i(wr_data_i), .reload_i(reload_q),
    .cnt_o(cnt_q), .wrap_o(wrap)
  );

  // Next-state logic
  always_comb begin
    mode_d   = evt_mode_t'(wr_data_i[MODE_W-1:0]);
    reload_d = wr_data_i;
    flag_d   = wr_data_i[0];
    pulse_d  = pulse_q ^ (wrap && mode_q.pulse_en);
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      reload_q <= '0;
      flag_q   <= 1'b0;
      pulse_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (mode_we)   mode_q   <= mode_d;
      if (reload_we) reload_q <= reload_d;
      if (flag_we)   flag_q   <= flag_d;
      pulse_q <= pulse_d;
      irq_q   <= wrap;
    end
  end

  always_comb begin
    case (rd_addr_i)
      ADDR_MODE: rd_data_o = {{PAD_MODE{1'b0}}, mode_q};
      ADDR_CNT:  rd_data_o = cnt_q;
      ADDR_DIR:  rd_data_o = {{PAD_FLAG{1'b0}}, flag_q};
      default:   rd_data_o = '0;
    endcase
  end

  assign irq_o      = irq_q;
  assign pulse_oe_o = mode_q.pulse_en;
  assign pulse_o    = pulse_q && mode_q.pulse_en;
endmodule

// File: rtl/evt_counter_checker.sv
module evt_counter_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic             irq_o,
  input logic             pulse_o,
  input logic [7:0]       mode_i,
  input logic [CNT_W-1:0] cnt_i
);
  // R8: the request never lasts more than one cycle
  a_r8_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R8: a request comes only from a counter that sat at a boundary
  a_r8_irq_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(cnt_i) == '0 || $past(cnt_i) == '1));

  // R2: a stopped counter holds unless preset through the register port
  a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1:0] != 2'b01 && !(wr_en_i && wr_addr_i == 2'd1)) |=> $stable(cnt_i));

  // R9: while enabled, the pulse line moves only together with a request
  a_r9_toggle_needs_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[2] && $past(mode_i[2]) && !$stable(pulse_o)) |-> irq_o);

  // R11: a running counter moves by at most one step outside a boundary crossing
  a_r11_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i[1:0]) == 2'b01 && !irq_o) |->
      (cnt_i == $past(cnt_i) || cnt_i == CNT_W'($past(cnt_i) + 1'b1) ||
       cnt_i == CNT_W'($past(cnt_i) - 1'b1)));
endmodule

bind evt_counter_timer evt_counter_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .irq_o(irq_o), .pulse_o(pulse_o), .mode_i(mode_q), .cnt_i(cnt_q)
);

// File: tb/evt_counter_timer_tb_top.sv
`timescale 1ns/1ps
module evt_counter_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        evt = 1'b0, dir = 1'b0;
  logic        pulse, pulse_oe, irq;

  int checks = 0, errors = 0, irq_seen = 0;
  logic [15:0] exp_cnt = '0, reload_v = '0;
  int          exp_irq = 0;
  logic        exp_pulse = 1'b0;
  logic        cur_evt = 1'b0;
  logic [7:0]  cur_mode = '0;

  always #4 clk = ~clk;

  evt_counter_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .evt_i(evt), .dir_i(dir), .pulse_o(pulse), .pulse_oe_o(pulse_oe), .irq_o(irq)
  );

  always @(negedge clk) if (irq) irq_seen++;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 2'd0) cur_mode = d[7:0];
    if (a == 2'd1) begin
      reload_v = d;
      if (cur_mode[1:0] != 2'b01) exp_cnt = d;
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  // Drive one level on the event pin and update the arithmetic model
  task automatic set_evt(logic lvl, logic up);
    logic hit;
    @(negedge clk);
    hit = (lvl != cur_evt) && (lvl == cur_mode[3]) && (cur_mode[1:0] == 2'b01);
    evt = lvl; cur_evt = lvl;
    if (hit) begin
      if (up ? (exp_cnt == 16'hFFFF) : (exp_cnt == 16'h0000)) begin
        exp_irq++;
        if (cur_mode[2]) exp_pulse = ~exp_pulse;
        exp_cnt = cur_mode[6] ? (up ? 16'h0000 : 16'hFFFF) : reload_v;
      end else begin
        exp_cnt = up ? exp_cnt + 16'd1 : exp_cnt - 16'd1;
      end
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic check_state(string tag);
    logic [15:0] v;
    rd(2'd1, v);
    check({tag, " count"}, v, exp_cnt);
    check({tag, " irq"}, irq_seen, exp_irq);
    check({tag, " pulse"}, pulse, cur_mode[2] ? exp_pulse : 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(2'd0, v); check("R1 mode", v, 16'h0000);
    rd(2'd1, v); check("R1 count", v, 16'h0000);
    rd(2'd2, v); check("R1 flag", v, 16'h0000);
    check("R1 irq", irq, 1'b0);
    check("R1 pulse", pulse, 1'b0);
    check("R1 pulse_oe", pulse_oe, 1'b0);

    // R10: preset while stopped
    wr(2'd1, 16'h0010);
    rd(2'd1, v); check("R10 stopped preset", v, 16'h0010);

    // R2: idle modes ignore edges
    wr(2'd2, 16'h0001);
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      wr(2'd0, 16'h0008 | 16'(m));
      set_evt(1'b1, 1'b1); set_evt(1'b0, 1'b1);
      check_state($sformatf("R2 idle mode %0d", m));
    end

    // R3 R4 R5: edge choice, direction source and direction value sweep
    for (int es = 0; es < 2; es++)
      for (int ds = 0; ds < 2; ds++)
        for (int dv = 0; dv < 2; dv++) begin
          wr(2'd0, 16'h0000);
          wr(2'd1, 16'h0100);
          wr(2'd2, ds ? 16'(!dv) : 16'(dv));
          dir = ds ? dv[0] : !dv[0];
          wr(2'd0, 16'h0001 | 16'(es << 3) | 16'(ds << 4));
          for (int k = 0; k < 6; k++) begin
            set_evt(!cur_evt, dv[0]);
            check_state($sformatf("%s es=%0d ds=%0d dv=%0d step=%0d",
                        ds ? "R5" : "R4 R3", es, ds, dv, k));
          end
        end

    // R6 R7 R8 R9: boundary crossings with the pulse enabled
    for (int fr = 0; fr < 2; fr++)
      for (int up = 0; up < 2; up++) begin
        wr(2'd0, 16'h0000);
        wr(2'd1, up ? 16'hFFFE : 16'h0001);
        wr(2'd2, 16'(up));
        wr(2'd0, 16'h0001 | 16'h0004 | 16'h0008 | 16'(fr << 6));
        check("R9 pulse_oe on", pulse_oe, 1'b1);
        for (int k = 0; k < 8; k++) begin
          set_evt(!cur_evt, up[0]);
          check_state($sformatf("%s R8 R9 up=%0d step=%0d", fr ? "R7" : "R6", up, k));
        end
      end

    // R9: with the pulse disabled, crossings still interrupt but the line stays low
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'hFFFF);
    wr(2'd2, 16'h0001);
    wr(2'd0, 16'h0049);
    check("R9 pulse_oe off", pulse_oe, 1'b0);
    for (int k = 0; k < 4; k++) begin
      set_evt(!cur_evt, 1'b1);
      check_state($sformatf("R9 disabled step=%0d", k));
    end

    // R10: a write while running changes only the reload value
    wr(2'd1, 16'h1234);
    rd(2'd1, v); check("R10 running write", v, exp_cnt);

    // R11: latency of three clock edges
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0020);
    wr(2'd0, 16'h0009);
    set_evt(1'b0, 1'b1);
    @(negedge clk);
    evt = 1'b1; cur_evt = 1'b1;
    repeat (2) @(negedge clk);
    rd(2'd1, v); check("R11 before third edge", v, 16'h0020);
    @(negedge clk);
    rd(2'd1, v); check("R11 at third edge", v, 16'h0021);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule